// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Bootstrap Refresh

This block turns one PWM logic input into two switch enables for a half-bridge power stage: one for the upper switch and one for the lower switch. Every handover between the two switches passes through a break-before-make interval in which both enables are low. All intervals are counted in cycles of a fixed system clock and set by parameters.

The upper switch may stay on only for a limited stretch. The upper switch is gate-driven from a bootstrap capacitor, and that capacitor recharges only while the lower switch conducts. So when PWM stays high for the full maximum on-time, the block forces the lower switch on for a short refresh window. That window is the maximum on-time divided by 128. After it, upper-switch conduction resumes if PWM is still high.

Three gating inputs force both switches off: standby, undervoltage lockout and a protection stop. The PWM input is resynchronised to the clock before it is used.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is active and after it is released, both enables are low until a dead interval has run its course.
- R2: With the synchronised PWM high and no gating active, after the dead interval the upper enable is high and the lower enable is low.
- R3: With the synchronised PWM low and no gating active, after the dead interval the lower enable is high and the upper enable is low.
- R4: Every rising edge of either enable is preceded by exactly DEAD_CYC consecutive cycles in which both enables are low.
- R5: The two enables are never high in the same cycle.
- R6: The upper enable never stays high for more than MAXON_CYC consecutive cycles. If PWM stays high, the upper enable drops after exactly MAXON_CYC cycles.
- R7: After a forced drop, the following happens in order: a dead interval, then the lower enable high for REFRESH_CYC = MAXON_CYC >> 7 cycles, then another dead interval. After that, the upper enable returns if PWM is still high.
- R8: If PWM falls during a refresh window, the lower enable stays high without a gap past the window's end.
- R9: Whenever standby, undervoltage lockout or protection stop is high at a clock edge, both enables are low from that edge on, whatever PWM does.
- R10: After the last gating input is released, the enable chosen by the PWM level rises at the (DEAD_CYC+1)-th clock edge.
- R11: With the default two synchroniser stages, the enable of the old side drops at the third rising clock edge after a PWM change.
- R12: At the end of an ordinary dead interval, the side that turns on is the one named by the synchronised PWM at that moment. A dead interval that leads into a refresh always ends with the lower side on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | PWM command, asynchronous to clk |
| standbyIn | input | 1 | Standby request, high forces both switches off |
| uvloIn | input | 1 | Undervoltage lockout active, high forces both off |
| faultStopIn | input | 1 | Overcurrent or thermal stop, high forces both off |
| hiEn | output | 1 | Upper switch enable |
| loEn | output | 1 | Lower switch enable |

## Verification
The hardest condition to reach is a PWM edge that lands inside a forced refresh window. The refresh starts only after a full maximum on-time of uninterrupted high PWM, and it lasts just a few cycles. The stimulus holds PWM high through two complete on-time periods and measures each interval of both enables. It then drops PWM at the first cycle of the second refresh and watches the lower enable stay high without a gap. Short random PWM pulses are also used to land edges inside dead intervals, which exercises the side re-selection at the end of a dead interval.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEAD,
    ST_HIGH,
    ST_LOW,
    ST_REFRESH
  } hbState_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clrDead;
    logic clrOn;
  } hbStrobe_t;

endpackage

// File: rtl/hb_pwm_sync.sv
module hb_pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= 1'b0;
    else       stg[0] <= dIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= 1'b0;
      else       stg[i] <= stg[i-1];
    end
  end

  assign dOut = stg[STAGES-1];
endmodule

// File: rtl/hb_gate_timers.sv
module hb_gate_timers
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC  = 4,
  parameter int MAXON_CYC = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  hbStrobe_t strobe,
  output logic      deadDone,
  output logic      maxOnHit,
  output logic      refreshDone
);
  localparam int DW          = $clog2(DEAD_CYC) + 1;
  localparam int OW          = $clog2(MAXON_CYC) + 1;
  localparam int REFRESH_CYC = ((MAXON_CYC >> 7) > 0) ? (MAXON_CYC >> 7) : 1;
  localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYC - 1);
  localparam logic [OW-1:0] ON_LAST   = OW'(MAXON_CYC - 1);
  localparam logic [OW-1:0] REF_LAST  = OW'(REFRESH_CYC - 1);

  logic [DW-1:0] deadCnt;
  logic [OW-1:0] onCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   deadCnt <= '0;
    else if (strobe.clrDead)     deadCnt <= '0;
    else if (deadCnt != DEAD_LAST) deadCnt <= deadCnt + 1'b1;
  end

  // one counter serves both the high-side on-time and the refresh window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 onCnt <= '0;
    else if (strobe.clrOn)     onCnt <= '0;
    else if (onCnt != ON_LAST) onCnt <= onCnt + 1'b1;
  end

  assign deadDone    = (deadCnt == DEAD_LAST);
  assign maxOnHit    = (onCnt == ON_LAST);
  assign refreshDone = (onCnt == REF_LAST);

  // a cleared counter cannot report completion in the following cycle (R4)
  assert_dead_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrDead && DEAD_CYC > 1) |=> !deadDone);
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwmSync,
  input  logic      gateOff,
  input  logic      deadDone,
  input  logic      maxOnHit,
  input  logic      refreshDone,
  output hbStrobe_t strobe,
  output logic      hiEn,
  output logic      loEn
);
  hbState_e state, nextState;
  logic     toRefresh, nextToRefresh;

  always_comb begin
    nextState     = state;
    nextToRefresh = toRefresh;
    if (gateOff) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nextState     = ST_DEAD;
          nextToRefresh = 1'b0;
        end
        ST_DEAD: begin
          if (deadDone) begin
            if (toRefresh)    nextState = ST_REFRESH;
            else if (pwmSync) nextState = ST_HIGH;
            else              nextState = ST_LOW;
          end
        end
        ST_HIGH: begin
          if (!pwmSync) begin
            nextState     = ST_DEAD;
            nextToRefresh = 1'b0;
          end else if (maxOnHit) begin
            nextState     = ST_DEAD;
            nextToRefresh = 1'b1;
          end
        end
        ST_LOW: begin
          if (pwmSync) begin
            nextState     = ST_DEAD;
            nextToRefresh = 1'b0;
          end
        end
        ST_REFRESH: begin
          if (refreshDone) begin
            if (pwmSync) begin
              nextState     = ST_DEAD;
              nextToRefresh = 1'b0;
            end else begin
              nextState = ST_LOW;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      toRefresh <= 1'b0;
    end else begin
      state     <= nextState;
      toRefresh <= nextToRefresh;
    end
  end

  always_comb begin
    strobe.clrDead = (nextState == ST_DEAD) && (state != ST_DEAD);
    strobe.clrOn   = ((nextState == ST_HIGH) || (nextState == ST_REFRESH))
                     && (nextState != state);
  end

  assign hiEn = (state == ST_HIGH);
  assign loEn = (state == ST_LOW) || (state == ST_REFRESH);

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(hiEn && loEn));

  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    gateOff |=> (!hiEn && !loEn));

  assert_dead_before_hi_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiEn) |-> $past(deadDone && !loEn));

  assert_dead_before_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loEn) |-> $past(deadDone && !hiEn));

  assert_max_on_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hiEn && maxOnHit) |=> !hiEn);
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int MAXON_CYC   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmIn,
  input  logic standbyIn,
  input  logic uvloIn,
  input  logic faultStopIn,
  output logic hiEn,
  output logic loEn
);
  logic      pwmSync;
  logic      gateOff;
  logic      deadDone, maxOnHit, refreshDone;
  hbStrobe_t strobe;

  assign gateOff = standbyIn | uvloIn | faultStopIn;

  hb_pwm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .dIn(pwmIn), .dOut(pwmSync)
  );

  hb_gate_timers #(.DEAD_CYC(DEAD_CYC), .MAXON_CYC(MAXON_CYC)) i_timers (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .deadDone(deadDone), .maxOnHit(maxOnHit), .refreshDone(refreshDone)
  );

  hb_gate_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pwmSync(pwmSync), .gateOff(gateOff),
    .deadDone(deadDone), .maxOnHit(maxOnHit), .refreshDone(refreshDone),
    .strobe(strobe), .hiEn(hiEn), .loEn(loEn)
  );
endmodule

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;
  localparam int DEAD  = 4;
  localparam int MAXON = 1024;
  localparam int REFR  = MAXON >> 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0, standbyIn = 1'b0, uvloIn = 1'b0, faultStopIn = 1'b0;
  logic hiEn, loEn;
  int checks = 0, errors = 0;
  bit modelOn = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_seq #(.DEAD_CYC(DEAD), .MAXON_CYC(MAXON), .SYNC_STAGES(2)) i_hb_gate_seq (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .standbyIn(standbyIn),
    .uvloIn(uvloIn), .faultStopIn(faultStopIn), .hiEn(hiEn), .loEn(loEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: modes 0 off,1 gap,2 upper,3 lower,4 recharge
  int mMode = 0, mAge = 0;
  bit mRecharge = 0;
  bit pwmQ[$];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mAge = 0; mRecharge = 0;
      pwmQ = '{1'b0, 1'b0};
    end else begin
      bit seen;
      seen = pwmQ[0];
      void'(pwmQ.pop_front());
      pwmQ.push_back(pwmIn);
      if (standbyIn || uvloIn || faultStopIn) begin
        mMode = 0; mAge = 0;
      end else if (mMode == 0) begin
        mMode = 1; mAge = 0; mRecharge = 0;
      end else if (mMode == 1) begin
        if (mAge + 1 >= DEAD) begin
          mMode = mRecharge ? 4 : (seen ? 2 : 3); mAge = 0;
        end else mAge++;
      end else if (mMode == 2) begin
        if (!seen) begin mMode = 1; mAge = 0; mRecharge = 0; end
        else if (mAge + 1 >= MAXON) begin mMode = 1; mAge = 0; mRecharge = 1; end
        else mAge++;
      end else if (mMode == 3) begin
        if (seen) begin mMode = 1; mAge = 0; mRecharge = 0; end
      end else begin
        if (mAge + 1 >= REFR) begin
          if (seen) begin mMode = 1; mRecharge = 0; end
          else mMode = 3;
          mAge = 0;
        end else mAge++;
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      bit expHi, expLo;
      string tag;
      expHi = (mMode == 2);
      expLo = (mMode == 3) || (mMode == 4);
      tag = (mMode == 2) ? "R2" : (mMode == 3) ? "R3" : (mMode == 4) ? "R7" :
            (mMode == 1) ? "R12" : "R9";
      check(hiEn == expHi, {tag, " upper enable"}, int'(hiEn), int'(expHi));
      check(loEn == expLo, {tag, " lower enable"}, int'(loEn), int'(expLo));
      check(!(hiEn && loEn), "R5 overlap", int'(hiEn && loEn), 0);
    end
  end

  task automatic gapLen(output int n);
    n = 0;
    while (!hiEn && !loEn && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic runLen(input bit upper, output int n);
    n = 0;
    while ((upper ? hiEn : loEn) && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic gateTest(input int which, input string req);
    int n;
    pwmIn = 1'b1;
    repeat (40) @(negedge clk);
    if (which == 0) standbyIn = 1'b1;
    else if (which == 1) uvloIn = 1'b1;
    else faultStopIn = 1'b1;
    @(negedge clk);
    check(!hiEn && !loEn, {req, " immediate off"}, int'(hiEn) + int'(loEn), 0);
    for (int i = 0; i < 30; i++) begin
      pwmIn = i[2];
      @(negedge clk);
      check(!hiEn && !loEn, {req, " held off"}, int'(hiEn) + int'(loEn), 0);
    end
    pwmIn = 1'b1;
    repeat (3) @(negedge clk);
    standbyIn = 1'b0; uvloIn = 1'b0; faultStopIn = 1'b0;
    n = 0;
    while (!hiEn && n < 100) begin @(negedge clk); n++; end
    check(n == DEAD + 1, "R10 restart edge", n, DEAD + 1);
  endtask

  task automatic mainFlow();
    int n;
    repeat (3) @(negedge clk);
    check(!hiEn && !loEn, "R1 in reset", int'(hiEn) + int'(loEn), 0);
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);
    check(!hiEn && !loEn, "R1 after release", int'(hiEn) + int'(loEn), 0);
    repeat (20) @(negedge clk);
    check(loEn && !hiEn, "R3 low pwm", int'(loEn), 1);
    // rising PWM: latency, gap, maximum on-time and refresh
    pwmIn = 1'b1;
    repeat (2) @(negedge clk);
    check(loEn == 1'b1, "R11 still old side", int'(loEn), 1);
    @(negedge clk);
    check(loEn == 1'b0, "R11 third edge", int'(loEn), 0);
    gapLen(n);  check(n == DEAD, "R4 gap to upper", n, DEAD);
    check(hiEn == 1'b1, "R2 upper on", int'(hiEn), 1);
    runLen(1'b1, n); check(n == MAXON, "R6 upper run", n, MAXON);
    gapLen(n);  check(n == DEAD, "R7 gap before refresh", n, DEAD);
    runLen(1'b0, n); check(n == REFR, "R7 refresh length", n, REFR);
    gapLen(n);  check(n == DEAD, "R7 gap after refresh", n, DEAD);
    check(hiEn == 1'b1, "R7 upper resumes", int'(hiEn), 1);
    runLen(1'b1, n); check(n == MAXON, "R6 second run", n, MAXON);
    gapLen(n);  check(n == DEAD, "R4 gap before second refresh", n, DEAD);
    // PWM falls at the first refresh cycle
    pwmIn = 1'b0;
    for (int i = 0; i < 3 * REFR + 10; i++) begin
      check(loEn && !hiEn, "R8 lower held through refresh end", int'(loEn), 1);
      @(negedge clk);
    end
    // PWM falling from upper side
    pwmIn = 1'b1;
    repeat (3) @(negedge clk);
    gapLen(n);
    repeat (10) @(negedge clk);
    pwmIn = 1'b0;
    repeat (2) @(negedge clk);
    check(hiEn == 1'b1, "R11 upper before third edge", int'(hiEn), 1);
    @(negedge clk);
    check(hiEn == 1'b0, "R11 upper drops", int'(hiEn), 0);
    gapLen(n);  check(n == DEAD, "R4 gap to lower", n, DEAD);
    check(loEn == 1'b1, "R3 lower on", int'(loEn), 1);
    gateTest(0, "R9 standby");
    gateTest(1, "R9 lockout");
    gateTest(2, "R9 fault stop");
    // short random pulses land edges inside gaps (R12), model compares each cycle
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 5) == 0) pwmIn = ~pwmIn;
      @(negedge clk);
    end
    pwmIn = 1'b1;
    repeat (2 * MAXON + 100) @(negedge clk);
  endtask

  initial begin
    fork
      mainFlow();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule